// File: doc/BRIEF.md
# Address-Match Debug Break Unit

This unit sits beside a processor core and raises a debug break request when a bus access hits a programmed address under a programmed set of conditions. It watches the instruction-fetch bus and the data bus. Each fetch returns one word that holds several short instructions, and every instruction slot in the word is compared on its own. A fetch match is recorded as a tag holding the matching instruction's address. The request is raised when that instruction shows up at the execute stage, so the first instruction of a word can run and the break still lands on the second.

A fetch break is precise. The request comes before the tagged instruction executes, and the saved PC is that instruction's address. There is one exception. If the tagged instruction is in a delayed-branch slot, or directly follows an instruction that holds off interrupts, it executes, and the break moves to the next instruction boundary that can accept an exception. A data break is imprecise. It is latched and taken at the first acceptable boundary after the access, and the saved PC is the instruction about to execute there.

The break address, mask, cycle-type enables and master enables arrive as plain inputs. Only one break can be in flight at a time, and it lasts until the core acknowledges exception entry.

Top module: `dbrk_unit`

## Requirements
- R1: While reset is asserted and right after it, `brk_req` is 0 and `saved_pc` is 0.
- R2: Each 16-bit slot of a fetched 32-bit word has its own address: the word base, and the base plus 2. A break set on the base plus 2 gives no request while the slot at the base executes. The request comes when the instruction at the base plus 2 reaches execute.
- R3: A fetch or data compare ignores every bit set in `brk_mask`. A fetch compare also ignores address bit 0. Any other bit that differs stops the match.
- R4: A fetch matches only when `cfg_fetch_en` is 1. A data read (`da_write`=0) matches only when `cfg_read_en` is 1. A data write (`da_write`=1) matches only when `cfg_write_en` is 1.
- R5: A data access matches only when bit `da_master` of `cfg_master_en` is 1. The master codes are 0 for the CPU, 1 for the transfer controller and 2 for DMA. Code 3 never matches.
- R6: An instruction is at an acceptable boundary when it is not a delay slot and the instruction before it did not hold off interrupts. If a tagged instruction reaches execute (`ex_valid` with `ex_pc` equal to the tag) at such a boundary, `brk_req` goes to 1 on the next clock, with `saved_pc` equal to that address.
- R7: If the tagged instruction is a delay slot (`ex_delay_slot`=1), no request is raised for it. The request follows the next execute-stage instruction at an acceptable boundary, and `saved_pc` is that instruction's address.
- R8: If the tagged instruction follows an instruction with `ex_blocks_irq`=1, the same deferral as R7 applies. The deferral carries on through any further instructions that are not at acceptable boundaries.
- R9: A data match is latched. The request follows the first execute-stage instruction at an acceptable boundary after the access cycle, and `saved_pc` is that instruction's address.
- R10: `brk_req` and `saved_pc` hold until `brk_ack` is sampled high. `brk_req` is 0 from the following clock.
- R11: While a break is tagged, latched or requested, new fetch and data matches are discarded. They give no request after the acknowledge.
- R12: `ex_flush` drops a fetch tag whose instruction has not yet reached execute. It has no effect on a latched data break.
- R13: If a fetch match and a data match arrive in the same cycle, the fetch match is kept and the data match is discarded.
- R14: If more than one slot of a fetched word matches, the lowest-addressed slot is tagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | AW | Break address |
| cfg_mask | input | AW | Address bits excluded from the compare |
| cfg_fetch_en | input | 1 | Enable fetch matches |
| cfg_read_en | input | 1 | Enable data-read matches |
| cfg_write_en | input | 1 | Enable data-write matches |
| cfg_master_en | input | NMST | Per-master enable for data matches |
| if_valid | input | 1 | Fetch cycle strobe |
| if_addr | input | AW | Fetch word address |
| da_valid | input | 1 | Data access strobe |
| da_addr | input | AW | Data access address |
| da_write | input | 1 | 1 = write, 0 = read |
| da_master | input | MW | Bus master code of the data access |
| ex_valid | input | 1 | An instruction is at the execute stage |
| ex_pc | input | AW | Address of that instruction |
| ex_delay_slot | input | 1 | That instruction is a delayed-branch slot |
| ex_blocks_irq | input | 1 | That instruction holds off interrupts for the one after it |
| ex_flush | input | 1 | Fetched instructions not yet executed are discarded |
| brk_ack | input | 1 | Exception entry acknowledged |
| brk_req | output | 1 | Debug break request |
| saved_pc | output | AW | PC to save on exception entry |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, 32-bit fetch words made of two 16-bit slots, and three bus masters on a 2-bit master code. With these values the second-slot case, the both-slots tie and the unmapped master code 3 can all be reached. Deferrals are driven by delay-slot and interrupt-holding instructions, including one chain of two non-accepting boundaries. Each expected saved PC is queued before the execute-stage instruction that should raise the request.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TAGGED,
    ST_ARMED,
    ST_REQ
  } dbrk_state_e;

  localparam int unsigned CMP_W = 64;

  // Masked equality: a set bit in ign removes that bit from the compare.
  function automatic logic addr_hit(input logic [CMP_W-1:0] a,
                                    input logic [CMP_W-1:0] b,
                                    input logic [CMP_W-1:0] ign);
    return ((a ^ b) & ~ign) == '0;
  endfunction

endpackage

// File: rtl/dbrk_fetch_match.sv
module dbrk_fetch_match #(
  parameter int AW = 32,
  parameter int FW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_valid,
  input  logic [AW-1:0] if_addr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_mask,
  input  logic          cfg_fetch_en,
  output logic          hit,
  output logic [AW-1:0] hit_pc
);
  import dbrk_pkg::*;

  localparam int NSLOT      = FW / IW;
  localparam int SLOT_BYTES = IW / 8;
  localparam int WORD_BYTES = FW / 8;
  localparam int LOW        = $clog2(WORD_BYTES);

  logic [AW-1:0]    word_base;
  logic [AW-1:0]    slot_pc [NSLOT];
  logic [NSLOT-1:0] slot_hit;
  logic [NSLOT-1:0] slot_sel;

  assign word_base = {if_addr[AW-1:LOW], {LOW{1'b0}}};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_pc[g]  = word_base + AW'(g * SLOT_BYTES);
    assign slot_hit[g] = if_valid && cfg_fetch_en &&
                         addr_hit(CMP_W'(slot_pc[g]), CMP_W'(cfg_addr),
                                  CMP_W'(cfg_mask) | CMP_W'(SLOT_BYTES - 1));
  end

  // Lowest-addressed slot wins.
  always_comb begin
    slot_sel = '0;
    hit_pc   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        slot_sel = NSLOT'(1) << i;
        hit_pc   = slot_pc[i];
      end
    end
  end

  assign hit = |slot_hit;

  // R14
  slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));

  // R4
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (if_valid && cfg_fetch_en));

endmodule

// File: rtl/dbrk_data_match.sv
module dbrk_data_match #(
  parameter int AW   = 32,
  parameter int NMST = 3,
  parameter int MW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            da_valid,
  input  logic [AW-1:0]   da_addr,
  input  logic            da_write,
  input  logic [MW-1:0]   da_master,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [AW-1:0]   cfg_mask,
  input  logic            cfg_read_en,
  input  logic            cfg_write_en,
  input  logic [NMST-1:0] cfg_master_en,
  output logic            hit
);
  import dbrk_pkg::*;

  logic master_ok;
  logic type_ok;
  logic addr_ok;

  always_comb begin
    master_ok = 1'b0;
    for (int i = 0; i < NMST; i++) begin
      if (da_master == MW'(i) && cfg_master_en[i]) master_ok = 1'b1;
    end
  end

  assign type_ok = da_write ? cfg_write_en : cfg_read_en;
  assign addr_ok = addr_hit(CMP_W'(da_addr), CMP_W'(cfg_addr), CMP_W'(cfg_mask));
  assign hit     = da_valid && type_ok && master_ok && addr_ok;

  // R5
  master_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(da_master) < NMST));

endmodule

// File: rtl/dbrk_boundary.sv
module dbrk_boundary (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_valid,
  input  logic ex_delay_slot,
  input  logic ex_blocks_irq,
  output logic accept_ok
);
  logic prev_blocks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_blocks <= 1'b0;
    else if (ex_valid) prev_blocks <= ex_blocks_irq;
  end

  assign accept_ok = ex_valid && !ex_delay_slot && !prev_blocks;

  // R8
  blocked_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_blocks_irq) |=> !accept_ok);

endmodule

// File: rtl/dbrk_unit.sv
module dbrk_unit #(
  parameter int AW   = 32,
  parameter int FW   = 32,
  parameter int IW   = 16,
  parameter int NMST = 3,
  localparam int MW  = (NMST > 1) ? $clog2(NMST) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [AW-1:0]   cfg_mask,
  input  logic            cfg_fetch_en,
  input  logic            cfg_read_en,
  input  logic            cfg_write_en,
  input  logic [NMST-1:0] cfg_master_en,
  input  logic            if_valid,
  input  logic [AW-1:0]   if_addr,
  input  logic            da_valid,
  input  logic [AW-1:0]   da_addr,
  input  logic            da_write,
  input  logic [MW-1:0]   da_master,
  input  logic            ex_valid,
  input  logic [AW-1:0]   ex_pc,
  input  logic            ex_delay_slot,
  input  logic            ex_blocks_irq,
  input  logic            ex_flush,
  input  logic            brk_ack,
  output logic            brk_req,
  output logic [AW-1:0]   saved_pc
);
  import dbrk_pkg::*;

  dbrk_state_e   state;
  logic [AW-1:0] tag_pc;
  logic          f_hit;
  logic [AW-1:0] f_pc;
  logic          d_hit;
  logic          accept_ok;
  logic          tag_at_ex;

  dbrk_fetch_match #(.AW(AW), .FW(FW), .IW(IW)) i_fetch (
    .clk(clk), .rst_n(rst_n),
    .if_valid(if_valid), .if_addr(if_addr),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_fetch_en(cfg_fetch_en),
    .hit(f_hit), .hit_pc(f_pc)
  );

  dbrk_data_match #(.AW(AW), .NMST(NMST), .MW(MW)) i_data (
    .clk(clk), .rst_n(rst_n),
    .da_valid(da_valid), .da_addr(da_addr), .da_write(da_write),
    .da_master(da_master),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
    .cfg_read_en(cfg_read_en), .cfg_write_en(cfg_write_en),
    .cfg_master_en(cfg_master_en),
    .hit(d_hit)
  );

  dbrk_boundary i_bound (
    .clk(clk), .rst_n(rst_n),
    .ex_valid(ex_valid), .ex_delay_slot(ex_delay_slot),
    .ex_blocks_irq(ex_blocks_irq),
    .accept_ok(accept_ok)
  );

  assign tag_at_ex = ex_valid && (ex_pc == tag_pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tag_pc   <= '0;
      saved_pc <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (f_hit) begin
            state  <= ST_TAGGED;
            tag_pc <= f_pc;
          end else if (d_hit) begin
            state <= ST_ARMED;
          end
        end
        ST_TAGGED: begin
          if (ex_flush) begin
            state <= ST_IDLE;
          end else if (tag_at_ex) begin
            if (accept_ok) begin
              state    <= ST_REQ;
              saved_pc <= ex_pc;
            end else begin
              state <= ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (accept_ok) begin
            state    <= ST_REQ;
            saved_pc <= ex_pc;
          end
        end
        ST_REQ: begin
          if (brk_ack) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign brk_req = (state == ST_REQ);

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_ack) |=> brk_req);

  // R10
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && brk_ack) |=> !brk_req);

  // R10
  pc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_ack) |=> $stable(saved_pc));

  // R6
  rise_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> (saved_pc == $past(ex_pc)));

  // R7
  rise_not_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(ex_valid && !ex_delay_slot));

endmodule

// File: tb/test_dbrk_unit.sv
`timescale 1ns/1ps
module test_dbrk_unit;
  localparam int AW = 32;
  localparam int NMST = 3;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_addr = '0, cfg_mask = '0;
  logic cfg_fetch_en = 1'b0, cfg_read_en = 1'b0, cfg_write_en = 1'b0;
  logic [NMST-1:0] cfg_master_en = '0;
  logic if_valid = 1'b0;
  logic [AW-1:0] if_addr = '0;
  logic da_valid = 1'b0;
  logic [AW-1:0] da_addr = '0;
  logic da_write = 1'b0;
  logic [MW-1:0] da_master = '0;
  logic ex_valid = 1'b0;
  logic [AW-1:0] ex_pc = '0;
  logic ex_delay_slot = 1'b0, ex_blocks_irq = 1'b0, ex_flush = 1'b0;
  logic brk_ack = 1'b0;
  logic brk_req;
  logic [AW-1:0] saved_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit seen = 1'b0;
  logic [AW-1:0] exp_q[$];

  always #2 clk = ~clk;

  dbrk_unit i_dbrk_unit (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
    .cfg_fetch_en(cfg_fetch_en), .cfg_read_en(cfg_read_en),
    .cfg_write_en(cfg_write_en), .cfg_master_en(cfg_master_en),
    .if_valid(if_valid), .if_addr(if_addr),
    .da_valid(da_valid), .da_addr(da_addr), .da_write(da_write),
    .da_master(da_master),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_delay_slot(ex_delay_slot),
    .ex_blocks_irq(ex_blocks_irq), .ex_flush(ex_flush),
    .brk_ack(brk_ack), .brk_req(brk_req), .saved_pc(saved_pc)
  );

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every rising request must match the queued saved PC.
  always @(negedge clk) begin
    if (rst_n && brk_req && !seen) begin
      seen = 1'b1;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R11: actual unexpected request pc %h expected none", saved_pc);
      end else begin
        check("R6 saved_pc", saved_pc, exp_q.pop_front());
      end
    end
    if (!brk_req) seen = 1'b0;
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic expect_brk(input logic [AW-1:0] pc);
    exp_q.push_back(pc);
  endtask

  task automatic do_fetch(input logic [AW-1:0] a);
    if_valid = 1'b1; if_addr = a;
    cyc();
    if_valid = 1'b0;
  endtask

  task automatic do_data(input logic [AW-1:0] a, input logic w, input logic [MW-1:0] m);
    da_valid = 1'b1; da_addr = a; da_write = w; da_master = m;
    cyc();
    da_valid = 1'b0;
  endtask

  task automatic do_exec(input logic [AW-1:0] pc, input logic ds, input logic blk);
    ex_valid = 1'b1; ex_pc = pc; ex_delay_slot = ds; ex_blocks_irq = blk;
    cyc();
    ex_valid = 1'b0; ex_delay_slot = 1'b0; ex_blocks_irq = 1'b0;
  endtask

  task automatic do_ack();
    brk_ack = 1'b1;
    cyc();
    brk_ack = 1'b0;
    check("R10 clear after ack", AW'(brk_req), '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    cyc();
    check("R1 req in reset", AW'(brk_req), '0);
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    check("R1 req after reset", AW'(brk_req), '0);
    check("R1 pc after reset", saved_pc, '0);

    // R2 / R6: second slot selected, first slot runs free
    cfg_fetch_en = 1'b1; cfg_addr = 32'h1002;
    do_fetch(32'h1000);
    do_exec(32'h1000, 1'b0, 1'b0);
    check("R2 first slot no break", AW'(brk_req), '0);
    expect_brk(32'h1002);
    do_exec(32'h1002, 1'b0, 1'b0);
    check("R6 precise request", AW'(brk_req), 1);
    cyc(); cyc();
    check("R10 held without ack", AW'(brk_req), 1);
    check("R10 pc held", saved_pc, 32'h1002);
    do_ack();

    // R14: both slots match through mask on bit 1
    cfg_mask = 32'h2; cfg_addr = 32'h2000;
    do_fetch(32'h2000);
    expect_brk(32'h2000);
    do_exec(32'h2000, 1'b0, 1'b0);
    check("R14 lowest slot tagged", AW'(brk_req), 1);
    do_ack();

    // R3: masked bits ignored, unmasked bits compared
    cfg_mask = 32'hF0; cfg_addr = 32'h3000;
    do_fetch(32'h30A0);
    expect_brk(32'h30A0);
    do_exec(32'h30A0, 1'b0, 1'b0);
    check("R3 masked match", AW'(brk_req), 1);
    do_ack();
    cfg_mask = '0;
    do_fetch(32'h3100);
    do_exec(32'h3100, 1'b0, 1'b0);
    check("R3 unmasked bit blocks", AW'(brk_req), '0);

    // R7: delay slot deferral
    cfg_addr = 32'h4004;
    do_fetch(32'h4004);
    do_exec(32'h4004, 1'b1, 1'b0);
    check("R7 no break in delay slot", AW'(brk_req), '0);
    expect_brk(32'h4006);
    do_exec(32'h4006, 1'b0, 1'b0);
    check("R7 deferred request", AW'(brk_req), 1);
    do_ack();

    // R8: interrupt-holding predecessor, chained with a delay slot
    cfg_addr = 32'h5002;
    do_fetch(32'h5000);
    do_exec(32'h5000, 1'b0, 1'b1);
    do_exec(32'h5002, 1'b0, 1'b0);
    check("R8 no break after blocker", AW'(brk_req), '0);
    do_exec(32'h5004, 1'b1, 1'b0);
    check("R8 chain still deferred", AW'(brk_req), '0);
    expect_brk(32'h5006);
    do_exec(32'h5006, 1'b0, 1'b0);
    check("R8 deferred request", AW'(brk_req), 1);
    do_ack();

    // R9: data read break by CPU
    cfg_fetch_en = 1'b0; cfg_read_en = 1'b1; cfg_master_en = 3'b001;
    cfg_addr = 32'h8000_0010;
    do_data(32'h8000_0010, 1'b0, 2'd0);
    check("R9 no request before boundary", AW'(brk_req), '0);
    do_exec(32'h6000, 1'b1, 1'b0);
    check("R9 waits past delay slot", AW'(brk_req), '0);
    expect_brk(32'h6002);
    do_exec(32'h6002, 1'b0, 1'b0);
    check("R9 data request", AW'(brk_req), 1);
    do_ack();

    // R4: cycle type gating
    do_data(32'h8000_0010, 1'b1, 2'd0);
    do_fetch(32'h8000_0010);
    do_exec(32'h8000_0010, 1'b0, 1'b0);
    check("R4 write and fetch disabled", AW'(brk_req), '0);
    cfg_write_en = 1'b1;
    do_data(32'h8000_0010, 1'b1, 2'd0);
    expect_brk(32'h6010);
    do_exec(32'h6010, 1'b0, 1'b0);
    check("R4 write enabled", AW'(brk_req), 1);
    do_ack();

    // R5: master select
    cfg_master_en = 3'b100;
    do_data(32'h8000_0010, 1'b0, 2'd0);
    do_exec(32'h6020, 1'b0, 1'b0);
    check("R5 CPU not selected", AW'(brk_req), '0);
    do_data(32'h8000_0010, 1'b0, 2'd2);
    expect_brk(32'h6022);
    do_exec(32'h6022, 1'b0, 1'b0);
    check("R5 DMA selected", AW'(brk_req), 1);
    do_ack();
    cfg_master_en = 3'b111;
    do_data(32'h8000_0010, 1'b0, 2'd3);
    do_exec(32'h6024, 1'b0, 1'b0);
    check("R5 unmapped master", AW'(brk_req), '0);

    // R11: matches while pending are discarded
    cfg_fetch_en = 1'b1; cfg_master_en = 3'b001; cfg_addr = 32'h7100;
    do_data(32'h7100, 1'b0, 2'd0);
    do_fetch(32'h7100);
    do_data(32'h7100, 1'b0, 2'd0);
    expect_brk(32'h6030);
    do_exec(32'h6030, 1'b0, 1'b0);
    check("R11 first request", AW'(brk_req), 1);
    do_fetch(32'h7100);
    do_ack();
    do_exec(32'h7100, 1'b0, 1'b0);
    check("R11 discarded matches", AW'(brk_req), '0);
    do_exec(32'h6040, 1'b0, 1'b0);
    check("R11 no late data break", AW'(brk_req), '0);

    // R12: flush drops fetch tag, not data
    cfg_addr = 32'h7200;
    do_fetch(32'h7200);
    ex_flush = 1'b1; cyc(); ex_flush = 1'b0;
    do_exec(32'h7200, 1'b0, 1'b0);
    check("R12 flushed tag", AW'(brk_req), '0);
    do_data(32'h7200, 1'b0, 2'd0);
    ex_flush = 1'b1; cyc(); ex_flush = 1'b0;
    expect_brk(32'h6050);
    do_exec(32'h6050, 1'b0, 1'b0);
    check("R12 data survives flush", AW'(brk_req), 1);
    do_ack();

    // R13: fetch wins over same-cycle data match
    cfg_addr = 32'h7300;
    if_valid = 1'b1; if_addr = 32'h7300;
    da_valid = 1'b1; da_addr = 32'h7300; da_write = 1'b0; da_master = 2'd0;
    cyc();
    if_valid = 1'b0; da_valid = 1'b0;
    do_exec(32'h6060, 1'b0, 1'b0);
    check("R13 data discarded", AW'(brk_req), '0);
    expect_brk(32'h7300);
    do_exec(32'h7300, 1'b0, 1'b0);
    check("R13 fetch kept", AW'(brk_req), 1);
    do_ack();

    cyc();
    check("R11 scoreboard drained", AW'(exp_q.size()), '0);
    finish_run();
  end
endmodule